// File: doc/BRIEF.md
# Whole-Method Instruction Cache Controller

This block manages an instruction cache whose unit of storage is a complete method rather than a fixed-size line. Resident methods occupy a circular code buffer. They are chained in a list in the order they were loaded. A bump pointer hands out exactly as many words as each new method needs, so short methods leave no padding behind. Cache misses can only occur at a call or a return. The processor presents the target method's start address (its tag) and its length. The controller compares the tag against a window of at most three list entries: the current method, the method that was current before it, and the most recently loaded method other than the current one. A target outside that window is a miss, even if it is still resident. This keeps hit and miss decidable from the local call history alone.

On a miss the controller fetches the method word by word from a backing memory port with a valid/ready handshake. It writes the words at consecutive, wrapping buffer addresses. When words or list slots run short, it drops the oldest methods from the tail of the list. Once a request has settled, instruction fetches inside the current method always hit. A fetch is served by offset from the method's base, with the data one cycle later.

Top module: `mcache_ctrl`

## Requirements
- R1: After reset, busy_o, mem_valid_o, req_err_o, fetch_rvalid_o and fetch_err_o are low.
- R2: A miss keeps busy_o high for 1 + L cycles when mem_ready_i stays high (L = method length). It reports hit_o = 0 and requests backing addresses tag, tag+1, ..., tag+L-1 in that order, one word per accepted handshake.
- R3: A call or return whose tag matches the current method, its caller, or the most recently loaded other method keeps busy_o high for exactly one cycle. It reports hit_o = 1 and issues no backing memory request.
- R4: A resident method that is not in the three-entry window counts as a miss and is loaded again.
- R5: A fetch accepted while busy_o is low returns, on the following cycle with fetch_rvalid_o high, the word stored at buffer address (base of the current method + offset) modulo 256.
- R6: A fetch whose offset is not below the current method's length, or one made before any method is loaded, raises fetch_err_o together with fetch_rvalid_o.
- R7: Each new method is placed at the bump pointer, directly after the previously loaded method. It wraps modulo the 256-word buffer, so a method that crosses the buffer end reads back correctly at every offset.
- R8: When free words or list slots are too few for a new method, the oldest methods are evicted from the list tail until it fits. An evicted method misses on its next call.
- R9: A request with length 0 or length above 256 is rejected: req_err_o is high, busy_o lasts one cycle, no backing request is made, and the current method stays in place for fetches.
- R10: While mem_ready_i is low, the load stalls with mem_valid_o high and mem_addr_o held. The words are still stored correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Call or return request, taken when busy_o is low |
| req_tag_i | input | 16 | Start address of the target method in backing memory |
| req_len_i | input | 9 | Length of the target method in words |
| busy_o | output | 1 | Request in progress; fetches are ignored while high |
| hit_o | output | 1 | Last request hit the window |
| req_err_o | output | 1 | Last request was rejected for its length |
| mem_valid_o | output | 1 | Backing memory word request |
| mem_addr_o | output | 16 | Backing memory word address |
| mem_ready_i | input | 1 | Backing memory accepts the request; data valid this cycle |
| mem_rdata_i | input | 32 | Backing memory read data |
| fetch_valid_i | input | 1 | Instruction fetch request |
| fetch_off_i | input | 9 | Word offset inside the current method |
| fetch_rvalid_o | output | 1 | Fetch response valid |
| fetch_data_o | output | 32 | Fetched instruction word |
| fetch_err_o | output | 1 | Fetch offset outside the current method |

## Verification
The assertions take for granted that the backing memory returns data in the same cycle it raises ready, and that requests are only presented while busy_o is low. They also assume the buffer depth and slot count are powers of two, so pointer wrap comes from truncation. The bench holds requests for one cycle at a time and waits for busy_o to fall before the next one. It drives read data combinationally from the address, and toggles ready only inside a dedicated stall scenario. This keeps every handshake inside the single-cycle read contract that the address-hold and eviction-room properties rely on.

// File: rtl/mcache_pkg.sv
package mcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RESP  = 2'd1,
    ST_ALLOC = 2'd2,
    ST_LOAD  = 2'd3
  } mc_state_e;
endpackage

// File: rtl/mcache_store.sv
module mcache_store #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/mcache_list.sv
module mcache_list #(
  parameter int NUM_ENT = 8,
  parameter int TAG_W   = 16,
  parameter int DEPTH   = 256,
  localparam int AW     = $clog2(DEPTH),
  localparam int LEN_W  = AW + 1,
  localparam int EW     = $clog2(NUM_ENT),
  localparam int CW     = $clog2(NUM_ENT + 1)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            alloc_i,
  input  logic [TAG_W-1:0]                alloc_tag_i,
  input  logic [AW-1:0]                   alloc_base_i,
  input  logic [LEN_W-1:0]                alloc_len_i,
  input  logic                            evict_i,
  output logic [NUM_ENT-1:0]              ent_vld_o,
  output logic [NUM_ENT-1:0][TAG_W-1:0]   ent_tag_o,
  output logic [NUM_ENT-1:0][AW-1:0]      ent_base_o,
  output logic [NUM_ENT-1:0][LEN_W-1:0]   ent_len_o,
  output logic [EW-1:0]                   head_o,
  output logic [CW-1:0]                   count_o,
  output logic [LEN_W-1:0]                used_o
);
  logic [EW-1:0]    head_q, tail_q;
  logic [CW-1:0]    count_q;
  logic [LEN_W-1:0] used_q;
  logic             evict_eff;
  logic [LEN_W-1:0] add_len, sub_len;

  assign evict_eff = evict_i && (count_q != '0);
  assign add_len   = alloc_i   ? alloc_len_i       : '0;
  assign sub_len   = evict_eff ? ent_len_o[tail_q] : '0;

  function automatic logic [EW-1:0] nxt(input logic [EW-1:0] p);
    return (p == EW'(NUM_ENT - 1)) ? '0 : p + EW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q     <= '0;
      tail_q     <= '0;
      count_q    <= '0;
      used_q     <= '0;
      ent_vld_o  <= '0;
      ent_tag_o  <= '0;
      ent_base_o <= '0;
      ent_len_o  <= '0;
    end else begin
      if (evict_eff) begin
        ent_vld_o[tail_q] <= 1'b0;
        tail_q            <= nxt(tail_q);
      end
      if (alloc_i) begin
        ent_vld_o[head_q]  <= 1'b1;
        ent_tag_o[head_q]  <= alloc_tag_i;
        ent_base_o[head_q] <= alloc_base_i;
        ent_len_o[head_q]  <= alloc_len_i;
        head_q             <= nxt(head_q);
      end
      count_q <= count_q + CW'(alloc_i) - CW'(evict_eff);
      used_q  <= used_q + add_len - sub_len;
    end
  end

  assign head_o  = head_q;
  assign count_o = count_q;
  assign used_o  = used_q;

  p_count_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(NUM_ENT));
  p_used_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_q <= LEN_W'(DEPTH));
  p_alloc_room_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> (count_q < CW'(NUM_ENT)) && (used_q + alloc_len_i <= LEN_W'(DEPTH)));
endmodule

// File: rtl/mcache_window.sv
module mcache_window #(
  parameter int NUM_ENT = 8,
  parameter int TAG_W   = 16,
  localparam int EW     = $clog2(NUM_ENT)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_ENT-1:0]            ent_vld_i,
  input  logic [NUM_ENT-1:0][TAG_W-1:0] ent_tag_i,
  input  logic [TAG_W-1:0]              req_tag_i,
  input  logic                          upd_i,
  input  logic                          upd_new_i,
  input  logic [EW-1:0]                 upd_idx_i,
  output logic                          hit_o,
  output logic [EW-1:0]                 hit_idx_o,
  output logic                          cur_vld_o,
  output logic [EW-1:0]                 cur_idx_o
);
  logic [EW-1:0] cur_q, prev_q, last_q, prior_q;
  logic          cur_v, prev_v, last_v, prior_v;
  logic [EW-1:0] alt_idx;
  logic          alt_v;
  logic          m_cur, m_prev, m_alt;

  // third slot: newest load that is not the current method
  always_comb begin
    if (last_v && (last_q != cur_q)) begin
      alt_idx = last_q;
      alt_v   = 1'b1;
    end else begin
      alt_idx = prior_q;
      alt_v   = prior_v;
    end
  end

  assign m_cur  = cur_v  && ent_vld_i[cur_q]   && (ent_tag_i[cur_q]   == req_tag_i);
  assign m_prev = prev_v && ent_vld_i[prev_q]  && (ent_tag_i[prev_q]  == req_tag_i);
  assign m_alt  = alt_v  && ent_vld_i[alt_idx] && (ent_tag_i[alt_idx] == req_tag_i);

  always_comb begin
    hit_o     = m_cur | m_prev | m_alt;
    hit_idx_o = m_cur ? cur_q : (m_prev ? prev_q : alt_idx);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0; prev_q <= '0; last_q <= '0; prior_q <= '0;
      cur_v <= 1'b0; prev_v <= 1'b0; last_v <= 1'b0; prior_v <= 1'b0;
    end else if (upd_i) begin
      prev_q <= cur_q;
      prev_v <= cur_v;
      cur_q  <= upd_idx_i;
      cur_v  <= 1'b1;
      if (upd_new_i) begin
        prior_q <= last_q;
        prior_v <= last_v;
        last_q  <= upd_idx_i;
        last_v  <= 1'b1;
      end
    end
  end

  assign cur_vld_o = cur_v;
  assign cur_idx_o = cur_q;

  p_new_is_live_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && upd_new_i) |=> ent_vld_i[cur_idx_o] && cur_vld_o);
endmodule

// File: rtl/mcache_ctrl.sv
module mcache_ctrl #(
  parameter int DEPTH   = 256,
  parameter int NUM_ENT = 8,
  parameter int TAG_W   = 16,
  parameter int DATA_W  = 32,
  localparam int AW     = $clog2(DEPTH),
  localparam int LEN_W  = AW + 1,
  localparam int EW     = $clog2(NUM_ENT),
  localparam int CW     = $clog2(NUM_ENT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              busy_o,
  output logic              hit_o,
  output logic              req_err_o,
  output logic              mem_valid_o,
  output logic [TAG_W-1:0]  mem_addr_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              fetch_valid_i,
  input  logic [LEN_W-1:0]  fetch_off_i,
  output logic              fetch_rvalid_o,
  output logic [DATA_W-1:0] fetch_data_o,
  output logic              fetch_err_o
);
  import mcache_pkg::*;

  mc_state_e        state_q;
  logic [TAG_W-1:0] tag_q;
  logic [LEN_W-1:0] len_q, idx_q;
  logic [AW-1:0]    bump_q;

  logic [NUM_ENT-1:0]            ent_vld;
  logic [NUM_ENT-1:0][TAG_W-1:0] ent_tag;
  logic [NUM_ENT-1:0][AW-1:0]    ent_base;
  logic [NUM_ENT-1:0][LEN_W-1:0] ent_len;
  logic [EW-1:0]                 head;
  logic [CW-1:0]                 count;
  logic [LEN_W-1:0]              used, free_w;

  logic          win_hit, cur_vld;
  logic [EW-1:0] hit_idx, cur_idx;

  logic accept, len_bad, take_word, last_word, commit, evict;
  logic win_upd, win_new;
  logic [EW-1:0] win_idx;
  logic fetch_acc, fetch_bad;
  logic [LEN_W-1:0] waddr_w, raddr_w;

  assign accept    = req_valid_i && (state_q == ST_IDLE);
  assign len_bad   = (req_len_i == '0) || (req_len_i > LEN_W'(DEPTH));
  assign take_word = (state_q == ST_LOAD) && mem_ready_i;
  assign last_word = (idx_q == len_q - LEN_W'(1));
  assign commit    = take_word && last_word;
  assign free_w    = LEN_W'(DEPTH) - used;

  // reclaim from the tail one entry per cycle while the load runs
  assign evict = ((state_q == ST_ALLOC) || (state_q == ST_LOAD)) && (count != '0) &&
                 ((free_w < len_q) || (count == CW'(NUM_ENT)));

  assign win_upd = (accept && !len_bad && win_hit) || commit;
  assign win_new = commit;
  assign win_idx = commit ? head : hit_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      tag_q     <= '0;
      len_q     <= '0;
      idx_q     <= '0;
      bump_q    <= '0;
      hit_o     <= 1'b0;
      req_err_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          req_err_o <= len_bad;
          hit_o     <= !len_bad && win_hit;
          tag_q     <= req_tag_i;
          len_q     <= req_len_i;
          idx_q     <= '0;
          state_q   <= (len_bad || win_hit) ? ST_RESP : ST_ALLOC;
        end
        ST_RESP:  state_q <= ST_IDLE;
        ST_ALLOC: state_q <= ST_LOAD;
        ST_LOAD: if (take_word) begin
          idx_q <= idx_q + LEN_W'(1);
          if (last_word) begin
            bump_q  <= AW'(LEN_W'(bump_q) + len_q);
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_valid_o = (state_q == ST_LOAD);
  assign mem_addr_o  = tag_q + TAG_W'(idx_q);

  assign fetch_acc = fetch_valid_i && (state_q == ST_IDLE);
  assign fetch_bad = !cur_vld || !ent_vld[cur_idx] || (fetch_off_i >= ent_len[cur_idx]);
  assign waddr_w   = LEN_W'(bump_q) + idx_q;
  assign raddr_w   = LEN_W'(ent_base[cur_idx]) + fetch_off_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_rvalid_o <= 1'b0;
      fetch_err_o    <= 1'b0;
    end else begin
      fetch_rvalid_o <= fetch_acc;
      fetch_err_o    <= fetch_acc && fetch_bad;
    end
  end

  mcache_list #(.NUM_ENT(NUM_ENT), .TAG_W(TAG_W), .DEPTH(DEPTH)) u_list (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_i      (commit),
    .alloc_tag_i  (tag_q),
    .alloc_base_i (bump_q),
    .alloc_len_i  (len_q),
    .evict_i      (evict),
    .ent_vld_o    (ent_vld),
    .ent_tag_o    (ent_tag),
    .ent_base_o   (ent_base),
    .ent_len_o    (ent_len),
    .head_o       (head),
    .count_o      (count),
    .used_o       (used)
  );

  mcache_window #(.NUM_ENT(NUM_ENT), .TAG_W(TAG_W)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ent_vld_i (ent_vld),
    .ent_tag_i (ent_tag),
    .req_tag_i (req_tag_i),
    .upd_i     (win_upd),
    .upd_new_i (win_new),
    .upd_idx_i (win_idx),
    .hit_o     (win_hit),
    .hit_idx_o (hit_idx),
    .cur_vld_o (cur_vld),
    .cur_idx_o (cur_idx)
  );

  mcache_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (take_word),
    .waddr_i (waddr_w[AW-1:0]),
    .wdata_i (mem_rdata_i),
    .re_i    (fetch_acc),
    .raddr_i (raddr_w[AW-1:0]),
    .rdata_o (fetch_data_o)
  );

  p_mem_in_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> busy_o);
  p_hit_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !len_bad && win_hit) |=> hit_o && !mem_valid_o && busy_o);
  p_hit_short_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !len_bad && win_hit) |=> ##1 !busy_o);
  p_reject_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && len_bad) |=> req_err_o && !mem_valid_o);
  p_addr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> mem_valid_o && $stable(mem_addr_o));
  p_fetch_resp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_acc |=> fetch_rvalid_o);
  p_fetch_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !fetch_rvalid_o);
endmodule

// File: tb/mcache_ctrl_test.sv
module mcache_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_tag = '0;
  logic [8:0]  req_len = '0;
  logic        busy, hit, req_err;
  logic        mem_valid;
  logic [15:0] mem_addr;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_rdata;
  logic        fetch_valid = 1'b0;
  logic [8:0]  fetch_off = '0;
  logic        fetch_rvalid, fetch_err;
  logic [31:0] fetch_data;

  int n_chk = 0;
  int n_fail = 0;
  bit stall_en = 1'b0;

  // backing memory monitor
  logic [15:0] mon_base = '0;
  int mon_cnt = 0;
  int mon_bad = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [15:0] a);
    return {a, ~a};
  endfunction

  assign mem_rdata = mem_word(mem_addr);

  mcache_ctrl uut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .req_valid_i    (req_valid),
    .req_tag_i      (req_tag),
    .req_len_i      (req_len),
    .busy_o         (busy),
    .hit_o          (hit),
    .req_err_o      (req_err),
    .mem_valid_o    (mem_valid),
    .mem_addr_o     (mem_addr),
    .mem_ready_i    (mem_ready),
    .mem_rdata_i    (mem_rdata),
    .fetch_valid_i  (fetch_valid),
    .fetch_off_i    (fetch_off),
    .fetch_rvalid_o (fetch_rvalid),
    .fetch_data_o   (fetch_data),
    .fetch_err_o    (fetch_err)
  );

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (mem_addr != mon_base + 16'(mon_cnt)) mon_bad++;
      mon_cnt++;
    end
  end

  always @(negedge clk) if (stall_en) mem_ready <= ~mem_ready;

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic do_req(input logic [15:0] tag, input logic [8:0] len, output int cyc);
    @(negedge clk);
    mon_base = tag;
    mon_cnt = 0;
    mon_bad = 0;
    req_valid = 1'b1;
    req_tag = tag;
    req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (busy) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic do_fetch(input logic [8:0] off, output logic [31:0] d, output logic e, output logic v);
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_off = off;
    @(negedge clk);
    fetch_valid = 1'b0;
    d = fetch_data;
    e = fetch_err;
    v = fetch_rvalid;
  endtask

  task automatic miss_load(input string rq, input logic [15:0] tag, input logic [8:0] len);
    int c;
    do_req(tag, len, c);
    check({rq, " miss busy cycles"}, c, 32'(len) + 1);
    check({rq, " miss hit flag"}, {31'b0, hit}, 0);
    check({rq, " words requested"}, mon_cnt, 32'(len));
    check({rq, " address order"}, mon_bad, 0);
  endtask

  task automatic window_hit(input string rq, input logic [15:0] tag, input logic [8:0] len);
    int c;
    do_req(tag, len, c);
    check({rq, " hit busy cycles"}, c, 1);
    check({rq, " hit flag"}, {31'b0, hit}, 1);
    check({rq, " no memory traffic"}, mon_cnt, 0);
  endtask

  task automatic fetch_ok(input string rq, input logic [8:0] off, input logic [15:0] tag);
    logic [31:0] d;
    logic e, v;
    do_fetch(off, d, e, v);
    check({rq, " fetch rvalid"}, {31'b0, v}, 1);
    check({rq, " fetch err"}, {31'b0, e}, 0);
    check({rq, " fetch data"}, d, mem_word(tag + 16'(off)));
  endtask

  task automatic fetch_bad(input string rq, input logic [8:0] off);
    logic [31:0] d;
    logic e, v;
    do_fetch(off, d, e, v);
    check({rq, " fetch rvalid"}, {31'b0, v}, 1);
    check({rq, " fetch err flag"}, {31'b0, e}, 1);
  endtask

  task automatic t_reset;
    check("R1 busy", {31'b0, busy}, 0);
    check("R1 mem_valid", {31'b0, mem_valid}, 0);
    check("R1 req_err", {31'b0, req_err}, 0);
    check("R1 fetch_rvalid", {31'b0, fetch_rvalid}, 0);
    check("R1 fetch_err", {31'b0, fetch_err}, 0);
    fetch_bad("R6 empty cache", 9'd0);
  endtask

  task automatic t_first_load;
    miss_load("R2 A", 16'h0100, 9'd5);
    for (int i = 0; i < 5; i++) fetch_ok("R5 A", 9'(i), 16'h0100);
    fetch_bad("R6 offset at length", 9'd5);
  endtask

  task automatic t_window;
    miss_load("R2 B", 16'h0200, 9'd3);
    window_hit("R3 caller", 16'h0100, 9'd5);
    fetch_ok("R5 back in A", 9'd2, 16'h0100);
    miss_load("R2 C", 16'h0300, 9'd4);
    window_hit("R3 recent load", 16'h0200, 9'd3);
    fetch_ok("R5 B", 9'd1, 16'h0200);
    window_hit("R3 current", 16'h0200, 9'd3);
    window_hit("R3 caller again", 16'h0300, 9'd4);
    window_hit("R3 back", 16'h0200, 9'd3);
    miss_load("R4 outside window", 16'h0100, 9'd5);
    fetch_ok("R4 reloaded A", 9'd4, 16'h0100);
  endtask

  task automatic t_reject;
    int c;
    do_req(16'h0700, 9'd0, c);
    check("R9 len 0 busy", c, 1);
    check("R9 len 0 err", {31'b0, req_err}, 1);
    check("R9 len 0 no traffic", mon_cnt, 0);
    do_req(16'h0700, 9'd257, c);
    check("R9 len 257 busy", c, 1);
    check("R9 len 257 err", {31'b0, req_err}, 1);
    check("R9 len 257 no traffic", mon_cnt, 0);
    fetch_ok("R9 current kept", 9'd3, 16'h0100);
  endtask

  task automatic t_evict_wrap;
    miss_load("R8 D", 16'h0400, 9'd200);
    fetch_ok("R7 D end", 9'd199, 16'h0400);
    miss_load("R8 E evicts", 16'h0500, 9'd100);
    fetch_ok("R7 E mid", 9'd10, 16'h0500);
    fetch_ok("R7 E last before wrap", 9'd38, 16'h0500);
    fetch_ok("R7 E first after wrap", 9'd39, 16'h0500);
    fetch_ok("R7 E tail", 9'd99, 16'h0500);
    miss_load("R8 D was evicted", 16'h0400, 9'd200);
    fetch_ok("R8 D reloaded", 9'd150, 16'h0400);
  endtask

  task automatic t_stall;
    int c;
    stall_en = 1'b1;
    do_req(16'h0600, 9'd6, c);
    stall_en = 1'b0;
    @(negedge clk);
    mem_ready = 1'b1;
    check("R10 stalled load longer", {31'b0, c > 7}, 1);
    check("R10 words requested", mon_cnt, 6);
    check("R10 address order", mon_bad, 0);
    for (int i = 0; i < 6; i++) fetch_ok("R10 data", 9'(i), 16'h0600);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_load();
    t_window();
    t_reject();
    t_evict_wrap();
    t_stall();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule